// File: doc/BRIEF.md
# Process-Indexed Page Mapping Unit

This block sits between the upper address lines of an 8-bit CPU with a 16-bit address bus and the RAM of a small computer. The low 32 KB of the address space is split into eight 4 KB logical pages. Address bits 14..12 name the logical page. They do not reach RAM directly. Instead they index an internal page table together with the current process identifier, and the table entry drives the three physical page lines of RAM. The block holds the identifier register and the table itself, so every process can have its own eight-entry map.

The supervisor is process 0. It loads the identifier register through a decoder select line. It rewrites table entries by storing to high addresses whose bit 11 is set: the bits 14..12 of that store pick the entry, and the entry is written for the identifier held at that moment. The top bit of the identifier marks user mode. While that bit is set, every table or identifier store is refused and raises a sticky fault flag. A dedicated clear strobe, driven by the interrupt or break entry path, returns the block to the supervisor by zeroing the identifier and the fault.

Top module: `pidx_map_unit`

## Requirements
- R1: After reset the identifier is 0, `user_mode` and `fault` are low, and the map of identifier 0 sends logical page 0 to physical page 1 and each logical page k from 1 to 7 to physical page k.
- R2: When `addr[15]` is 0, `ram_sel` is high and `phys_page` is the table entry selected by identifier bits 6..0 followed by `addr[14:12]`, in the same cycle.
- R3: When `addr[15]` is 1, `ram_sel` is low and `phys_page` equals `addr[14:12]`.
- R4: A store with `wr` and `phase` high and both `addr[15]` and `addr[11]` high writes `wdata[2:0]` into entry `addr[14:12]` of the current identifier at that clock edge, and the new mapping shows from the next cycle.
- R5: A store with `wr`, `phase` and `pid_sel` high loads `wdata` into the identifier register at that clock edge.
- R6: Maps of different identifiers are independent: a table store under one identifier leaves the entries of another unchanged.
- R7: `user_mode` follows identifier bit 7. While it is high, table stores and identifier stores have no effect.
- R8: A store refused under R7 sets `fault`, which stays high until the clear strobe.
- R9: A high `svc_clr` at a clock edge clears the whole identifier and `fault`, taking priority over any store in the same cycle.
- R10: A store with `addr[11]` low or with `phase` low does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | High during the data phase of a bus cycle |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU data bus |
| wr | input | 1 | CPU write strobe |
| pid_sel | input | 1 | Decoder select for the identifier register |
| svc_clr | input | 1 | Supervisor entry strobe, clears identifier and fault |
| phys_page | output | 3 | Physical page lines to RAM |
| ram_sel | output | 1 | High when the access is translated to RAM |
| user_mode | output | 1 | Identifier bit 7 |
| fault | output | 1 | Sticky refused-store flag |

## Verification
A wrong identifier shows on the very next translated access as a page from another process's map, and on `user_mode` at once if bit 7 is affected. A corrupted table entry stays hidden until that identifier and logical page are presented, then appears on `phys_page` in that same cycle. A store that should have been refused but landed shows on the next lookup of the touched entry, and a missed refusal shows one cycle later as a low `fault`.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 8;
    localparam int PID_W_DEF  = 8;
    localparam int PAGE_W_DEF = 3;

    // Decoded store command for one bus cycle
    typedef struct packed {
        logic table_we;
        logic pid_we;
        logic refused;
    } store_cmd_t;

    // Power-on map for identifier 0: page 0 moves to page 1, the rest stay
    function automatic logic [PAGE_W_DEF-1:0] boot_page(input int unsigned lp);
        logic [PAGE_W_DEF-1:0] r;
        r = PAGE_W_DEF'(lp);
        if (lp == 0) r = PAGE_W_DEF'(1);
        return r;
    endfunction

endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
    import pmu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int SEL_BIT = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              phase,
    input  logic              pid_sel,
    input  logic              user,
    output store_cmd_t        cmd,
    output logic [PAGE_W-1:0] lpage,
    output logic              bypass
);
    localparam int TOP = ADDR_W - 1;
    localparam int PG_LO = TOP - PAGE_W;

    logic strobe;
    logic table_hit;
    logic pid_hit;

    always_comb begin
        strobe    = wr & phase;
        bypass    = addr[TOP];
        lpage     = addr[TOP-1:PG_LO];
        table_hit = strobe & addr[TOP] & addr[SEL_BIT];
        pid_hit   = strobe & pid_sel;
        cmd.table_we = table_hit & ~user;
        cmd.pid_we   = pid_hit & ~user;
        cmd.refused  = (table_hit | pid_hit) & user;
    end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
#(
    parameter int PID_W = PID_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  store_cmd_t       cmd,
    input  logic [PID_W-1:0] wdata,
    input  logic             svc_clr,
    output logic [PID_W-1:0] pid,
    output logic             fault
);
    always_ff @(posedge clk) begin
        if (rst || svc_clr) begin
            pid   <= '0;
            fault <= 1'b0;
        end else begin
            if (cmd.pid_we)  pid   <= wdata;
            if (cmd.refused) fault <= 1'b1;
        end
    end
endmodule

// File: rtl/pmu_table.sv
module pmu_table
    import pmu_pkg::*;
#(
    parameter int TAG_W  = PID_W_DEF - 1,
    parameter int PAGE_W = PAGE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [TAG_W+PAGE_W-1:0] idx,
    input  logic [PAGE_W-1:0]       wpage,
    output logic [PAGE_W-1:0]       rpage
);
    localparam int IDX_W = TAG_W + PAGE_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam int PAGES = 1 << PAGE_W;

    logic [PAGE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGES; i++) mem[i] <= boot_page(i);
        end else if (we) begin
            mem[idx] <= wpage;
        end
    end

    assign rpage = mem[idx];
endmodule

// File: rtl/pidx_map_unit.sv
module pidx_map_unit
    import pmu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int PID_W  = PID_W_DEF,
    parameter int PAGE_W = PAGE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              pid_sel,
    input  logic              svc_clr,
    output logic [PAGE_W-1:0] phys_page,
    output logic              ram_sel,
    output logic              user_mode,
    output logic              fault
);
    localparam int TAG_W = PID_W - 1;

    store_cmd_t        cmd;
    logic [PAGE_W-1:0] lpage;
    logic              bypass;
    logic [PID_W-1:0]  pid;
    logic [PAGE_W-1:0] mapped;

    assign user_mode = pid[PID_W-1];

    pmu_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
        .addr(addr), .wr(wr), .phase(phase), .pid_sel(pid_sel),
        .user(user_mode), .cmd(cmd), .lpage(lpage), .bypass(bypass)
    );

    pmu_ctrl #(.PID_W(PID_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(wdata[PID_W-1:0]),
        .svc_clr(svc_clr), .pid(pid), .fault(fault)
    );

    pmu_table #(.TAG_W(TAG_W), .PAGE_W(PAGE_W)) u_tab (
        .clk(clk), .rst(rst), .we(cmd.table_we & ~svc_clr),
        .idx({pid[TAG_W-1:0], lpage}), .wpage(wdata[PAGE_W-1:0]),
        .rpage(mapped)
    );

    always_comb begin
        ram_sel   = ~bypass;
        phys_page = bypass ? lpage : mapped;
    end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              phase,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              pid_sel,
    input logic              svc_clr,
    input logic [PAGE_W-1:0] phys_page,
    input logic              ram_sel,
    input logic              user_mode,
    input logic              fault
);
    logic user_store;
    assign user_store = user_mode & wr & phase &
                        (pid_sel | (addr[ADDR_W-1] & addr[11]));

    p_ram_sel_r2: assert property (@(posedge clk) disable iff (rst)
        !addr[ADDR_W-1] |-> ram_sel);

    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        addr[ADDR_W-1] |-> (!ram_sel && phys_page == addr[ADDR_W-2:ADDR_W-1-PAGE_W]));

    p_user_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (user_mode && !svc_clr) |=> user_mode);

    p_fault_set_r8: assert property (@(posedge clk) disable iff (rst)
        (user_store && !svc_clr) |=> fault);

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fault && !svc_clr) |=> fault);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        svc_clr |=> (!user_mode && !fault));
endmodule

bind pidx_map_unit pmu_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .phase(phase), .addr(addr), .wr(wr),
    .pid_sel(pid_sel), .svc_clr(svc_clr), .phys_page(phys_page),
    .ram_sel(ram_sel), .user_mode(user_mode), .fault(fault)
);

// File: tb/sim_pidx_map_unit.sv
`timescale 1ns/1ps
module sim_pidx_map_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        pid_sel = 1'b0;
    logic        svc_clr = 1'b0;
    logic [2:0]  phys_page;
    logic        ram_sel, user_mode, fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pidx_map_unit u0 (
        .clk(clk), .rst(rst), .phase(phase), .addr(addr), .wdata(wdata),
        .wr(wr), .pid_sel(pid_sel), .svc_clr(svc_clr), .phys_page(phys_page),
        .ram_sel(ram_sel), .user_mode(user_mode), .fault(fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bus store; committed at the posedge, inputs idle afterwards
    task automatic store(input logic [15:0] a, input logic [7:0] d,
                         input logic ps, input logic ph, input logic clr);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; phase = ph; pid_sel = ps; svc_clr = clr;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; phase = 1'b0; pid_sel = 1'b0; svc_clr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        svc_clr = 1'b1;
        @(negedge clk);
        svc_clr = 1'b0;
    endtask

    task automatic look(input string req, input logic [15:0] a,
                        input int exp_page, input int exp_sel);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, int'(phys_page), exp_page);
        chk(req, int'(ram_sel), exp_sel);
    endtask

    task automatic t_reset();
        chk("R1 user", int'(user_mode), 0);
        chk("R1 fault", int'(fault), 0);
        for (int k = 0; k < 8; k++)
            look("R1 boot map", 16'(k << 12), (k == 0) ? 1 : k, 1);
    endtask

    task automatic t_bypass();
        look("R3 bypass", 16'hA123, 2, 0);
        look("R3 bypass", 16'hF000, 7, 0);
        look("R3 bypass", 16'h8FFF, 0, 0);
    endtask

    task automatic t_table_write();
        store(16'h9FFF, 8'h05, 1'b0, 1'b1, 1'b0);
        look("R4 entry1", 16'h1234, 5, 1);
        look("R2 entry2 untouched", 16'h2000, 2, 1);
        store(16'hB7FF, 8'h06, 1'b0, 1'b1, 1'b0);
        look("R10 a11 low", 16'h3000, 3, 1);
        store(16'hBFFF, 8'h06, 1'b0, 1'b0, 1'b0);
        look("R10 phase low", 16'h3000, 3, 1);
    endtask

    task automatic t_pid_maps();
        store(16'h0200, 8'h02, 1'b1, 1'b1, 1'b0);
        store(16'h8FFF, 8'h04, 1'b0, 1'b1, 1'b0);
        store(16'hCFFF, 8'h06, 1'b0, 1'b1, 1'b0);
        look("R5 pid2 page0", 16'h0000, 4, 1);
        look("R2 pid2 page4", 16'h4000, 6, 1);
        chk("R5 not user", int'(user_mode), 0);
        store(16'h0200, 8'h00, 1'b1, 1'b1, 1'b0);
        look("R6 pid0 page0", 16'h0000, 1, 1);
        look("R6 pid0 page4", 16'h4000, 4, 1);
    endtask

    task automatic t_user();
        store(16'h0200, 8'h82, 1'b1, 1'b1, 1'b0);
        chk("R7 user_mode", int'(user_mode), 1);
        chk("R8 no fault yet", int'(fault), 0);
        look("R2 user uses low bits", 16'h0000, 4, 1);
        store(16'h8FFF, 8'h07, 1'b0, 1'b1, 1'b0);
        look("R7 table locked", 16'h0000, 4, 1);
        chk("R8 fault set", int'(fault), 1);
        store(16'h0200, 8'h00, 1'b1, 1'b1, 1'b0);
        chk("R7 pid locked", int'(user_mode), 1);
        look("R7 pid locked map", 16'h4000, 6, 1);
        chk("R8 fault sticky", int'(fault), 1);
    endtask

    task automatic t_clear();
        pulse_clear();
        #1;
        chk("R9 user cleared", int'(user_mode), 0);
        chk("R9 fault cleared", int'(fault), 0);
        look("R9 back to pid0", 16'h0000, 1, 1);
        // clear beats simultaneous id store
        store(16'h0200, 8'h02, 1'b1, 1'b1, 1'b1);
        look("R9 clear priority", 16'h0000, 1, 1);
        // clear beats a refused store in user mode
        store(16'h0200, 8'h82, 1'b1, 1'b1, 1'b0);
        store(16'h8FFF, 8'h07, 1'b0, 1'b1, 1'b1);
        chk("R9 no fault on clear", int'(fault), 0);
        chk("R9 user off", int'(user_mode), 0);
        store(16'h0200, 8'h02, 1'b1, 1'b1, 1'b0);
        look("R9 pid2 map kept", 16'h0000, 4, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_bypass();
        t_table_write();
        t_pid_maps();
        t_user();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule